// File: doc/BRIEF.md
# Configurable Macrocell Storage Register

This block is the storage cell of a programmable-logic macrocell. A set of static configuration inputs decides how it behaves. It can act as a D, T, JK or SR flip-flop, or as a flow-through latch. Its data comes either from a sum term with adjustable polarity or from a dedicated product term. It is clocked by the global clock or by its own product-term clock, and it has optional clock gating and selectable asynchronous clear and set.

The cell runs on a fast system clock. The macrocell clock inputs (`gclk`, `pt_clk`) are sampled as data, so a rising edge of the selected macrocell clock is detected as a low-to-high change between two system clock samples. The asynchronous clear and set act on the output in the same cycle, with no register in their path. They also overwrite the stored state at the next system edge.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low, `q` is 0. After `rst_n` rises, `q` stays 0 until the first accepted update.
- R2: With `cfg_din_sel`=0, the data is `sum_term` XOR a polarity bit chosen by `cfg_pol_sel` (0 gives fixed low, 1 gives fixed high, 2 or 3 gives `pt_pol`). With `cfg_din_sel`=1, the data is `pt_data`.
- R3: In D mode (`cfg_mode`=0), `q` takes the data value on each accepted rising edge of the selected macrocell clock.
- R4: In T mode (`cfg_mode`=1), `q` inverts on an accepted edge when the data is 1 and holds when the data is 0.
- R5: In JK mode (`cfg_mode`=2), with J the data and K `k_term`, an accepted edge gives: 00 hold, 10 set, 01 clear, 11 toggle.
- R6: In SR mode (`cfg_mode`=3), with S the data and R `k_term`, an accepted edge gives: 10 set, 01 clear, and hold for both 00 and 11.
- R7: In latch mode (`cfg_mode`=4), `q` follows the data one system cycle later while the selected clock is high, and holds while it is low.
- R8: `cfg_clk_sel`=0 selects `gclk` and `cfg_clk_sel`=1 selects `pt_clk`. Edges on the clock that is not selected have no effect.
- R9: With `cfg_clk_sel`=0 and `cfg_ce_en`=1, edges are ignored while `pt_ce` is low. With `cfg_clk_sel`=1, `pt_ce` has no effect.
- R10: `cfg_ar_sel` picks the clear source: 0 none, 1 `gclr_n` low, 2 `pt_ar` high, 3 either one. An active clear forces `q` to 0 in the same cycle, and the stored state reads 0 after the clear is released.
- R11: With `cfg_ap_en`=1, `pt_ap` high forces `q` to 1 in the same cycle, and the stored state stays 1 after release. With `cfg_ap_en`=0, `pt_ap` has no effect.
- R12: When clear and set are active together, `q` is 0.
- R13: In flip-flop modes, `q` does not change while there is no accepted edge and no clear or set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all macrocell signals |
| rst_n | input | 1 | Power-up reset, active low, released through a synchronizer |
| cfg_mode | input | 3 | Storage behaviour: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_din_sel | input | 1 | 0 selects the polarity-adjusted sum term, 1 selects `pt_data` |
| cfg_pol_sel | input | 2 | Polarity operand: 0 low, 1 high, 2 or 3 `pt_pol` |
| cfg_clk_sel | input | 1 | 0 selects the global clock, 1 selects the product-term clock |
| cfg_ce_en | input | 1 | Enables `pt_ce` gating when the global clock is selected |
| cfg_ar_sel | input | 2 | Clear source: 0 none, 1 pin, 2 term, 3 either |
| cfg_ap_en | input | 1 | Enables the product-term set |
| sum_term | input | 1 | Sum-of-products term |
| pt_pol | input | 1 | Product term used as the polarity operand |
| pt_data | input | 1 | Dedicated data product term |
| k_term | input | 1 | Second operand, used as K in JK mode and as R in SR mode |
| gclk | input | 1 | Global macrocell clock |
| pt_clk | input | 1 | Individual product-term clock |
| pt_ce | input | 1 | Clock-enable product term |
| gclr_n | input | 1 | Global clear pin, active low |
| pt_ar | input | 1 | Clear product term, active high |
| pt_ap | input | 1 | Set product term, active high |
| q | output | 1 | Register output |

## Verification
Results from a macrocell clock edge are due at the first system edge that sees the raised clock. The bench raises the clock on a falling system edge, lowers it on the next falling edge and samples `q` on the falling edge after that. The same applies to latch updates while the clock is high. Clear, set and reset act on `q` at once, so the bench drives them on a falling edge and samples 1 ns later. It then waits one more full cycle to confirm the stored state after release. Checks that something is ignored sample `q` two or more cycles after the stimulus.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [SEL_W-1:0] {
    POL_LOW  = 2'd0,
    POL_HIGH = 2'd1,
    POL_TERM = 2'd2,
    POL_TRM2 = 2'd3
  } pol_e;

  typedef enum logic [SEL_W-1:0] {
    AR_OFF  = 2'd0,
    AR_PIN  = 2'd1,
    AR_TERM = 2'd2,
    AR_BOTH = 2'd3
  } ar_e;
endpackage

// File: rtl/mcell_din.sv
module mcell_din
  import mcell_pkg::*;
(
  input  logic             din_sel,
  input  logic [SEL_W-1:0] pol_sel,
  input  logic             sum_term,
  input  logic             pt_pol,
  input  logic             pt_data,
  output logic             din
);
  logic pol_bit;
  logic xor_out;

  always_comb begin
    unique case (pol_e'(pol_sel))
      POL_LOW:  pol_bit = 1'b0;
      POL_HIGH: pol_bit = 1'b1;
      default:  pol_bit = pt_pol;
    endcase
  end

  assign xor_out = sum_term ^ pol_bit;
  assign din     = din_sel ? pt_data : xor_out;
endmodule

// File: rtl/mcell_clkgen.sv
module mcell_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic ce_en,
  input  logic gclk,
  input  logic pt_clk,
  input  logic pt_ce,
  output logic tick,
  output logic level
);
  logic src;
  logic src_q;
  logic ce_ok;

  assign src   = clk_sel ? pt_clk : gclk;
  // gating applies to the global clock only
  assign ce_ok = (!clk_sel && ce_en) ? pt_ce : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign tick  = src & ~src_q & ce_ok;
  assign level = src & ce_ok;
endmodule

// File: rtl/mcell_next.sv
module mcell_next
  import mcell_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              din,
  input  logic              k_term,
  input  logic              state,
  input  logic              tick,
  input  logic              level,
  output logic              upd,
  output logic              nxt
);
  always_comb begin
    upd = tick;
    nxt = state;
    unique case (mode_e'(mode))
      MODE_D: nxt = din;
      MODE_T: nxt = state ^ din;
      MODE_JK: begin
        unique case ({din, k_term})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~state;
          default: nxt = state;
        endcase
      end
      MODE_SR: begin
        unique case ({din, k_term})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = state;
        endcase
      end
      MODE_LATCH: begin
        upd = level;
        nxt = din;
      end
      default: upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcell_async.sv
module mcell_async
  import mcell_pkg::*;
(
  input  logic [SEL_W-1:0] ar_sel,
  input  logic             ap_en,
  input  logic             gclr_n,
  input  logic             pt_ar,
  input  logic             pt_ap,
  output logic             clr,
  output logic             set
);
  always_comb begin
    unique case (ar_e'(ar_sel))
      AR_PIN:  clr = ~gclr_n;
      AR_TERM: clr = pt_ar;
      AR_BOTH: clr = ~gclr_n | pt_ar;
      default: clr = 1'b0;
    endcase
  end

  // clear wins over set
  assign set = ap_en & pt_ap & ~clr;
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic             cfg_din_sel,
  input  logic [SEL_W-1:0] cfg_pol_sel,
  input  logic             cfg_clk_sel,
  input  logic             cfg_ce_en,
  input  logic [SEL_W-1:0] cfg_ar_sel,
  input  logic             cfg_ap_en,
  input  logic             sum_term,
  input  logic             pt_pol,
  input  logic             pt_data,
  input  logic             k_term,
  input  logic             gclk,
  input  logic             pt_clk,
  input  logic             pt_ce,
  input  logic             gclr_n,
  input  logic             pt_ar,
  input  logic             pt_ap,
  output logic             q
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic rst_int_n;
  logic din, tick, level, upd, nxt, clr, set;
  logic state_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= 1'b0;
        else        rsync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= '0;
        else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  mcell_din u_din (
    .din_sel (cfg_din_sel),
    .pol_sel (cfg_pol_sel),
    .sum_term(sum_term),
    .pt_pol  (pt_pol),
    .pt_data (pt_data),
    .din     (din)
  );

  mcell_clkgen u_clk (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clk_sel(cfg_clk_sel),
    .ce_en  (cfg_ce_en),
    .gclk   (gclk),
    .pt_clk (pt_clk),
    .pt_ce  (pt_ce),
    .tick   (tick),
    .level  (level)
  );

  mcell_next u_next (
    .mode  (cfg_mode),
    .din   (din),
    .k_term(k_term),
    .state (state_q),
    .tick  (tick),
    .level (level),
    .upd   (upd),
    .nxt   (nxt)
  );

  mcell_async u_async (
    .ar_sel(cfg_ar_sel),
    .ap_en (cfg_ap_en),
    .gclr_n(gclr_n),
    .pt_ar (pt_ar),
    .pt_ap (pt_ap),
    .clr   (clr),
    .set   (set)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  state_q <= 1'b0;
    else if (clr)    state_q <= 1'b0;
    else if (set)    state_q <= 1'b1;
    else if (upd)    state_q <= nxt;
  end

  assign q = clr ? 1'b0 : (set ? 1'b1 : state_q);
endmodule

// File: rtl/mcell_reg_chk.sv
module mcell_reg_chk
  import mcell_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              cfg_clk_sel,
  input logic [SEL_W-1:0]  cfg_ar_sel,
  input logic              cfg_ap_en,
  input logic              gclk,
  input logic              gclr_n,
  input logic              pt_ar,
  input logic              pt_ap,
  input logic              din,
  input logic              k_term,
  input logic              state_q,
  input logic              q
);
  logic gclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gclk_d <= 1'b0;
    else        gclk_d <= gclk;
  end

  // R10
  clr_pin_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ar_sel[0] && !gclr_n) |-> !q);

  // R11
  set_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ap_en && pt_ap && !cfg_ar_sel[1] && !(cfg_ar_sel[0] && !gclr_n)) |-> q);

  // R12
  clear_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ar_sel[1] && pt_ar && cfg_ap_en && pt_ap) |-> !q);

  // R6
  sr_both_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_SR && din && k_term && cfg_ar_sel == AR_OFF && !cfg_ap_en)
    |=> $stable(state_q));

  // R13
  no_edge_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_D && !cfg_clk_sel && cfg_ar_sel == AR_OFF && !cfg_ap_en
     && !(gclk && !gclk_d)) |=> $stable(state_q));
endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .cfg_mode   (cfg_mode),
  .cfg_clk_sel(cfg_clk_sel),
  .cfg_ar_sel (cfg_ar_sel),
  .cfg_ap_en  (cfg_ap_en),
  .gclk       (gclk),
  .gclr_n     (gclr_n),
  .pt_ar      (pt_ar),
  .pt_ap      (pt_ap),
  .din        (din),
  .k_term     (k_term),
  .state_q    (state_q),
  .q          (q)
);

// File: tb/test_mcell_reg.sv
module test_mcell_reg;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_mode;
  logic cfg_din_sel, cfg_clk_sel, cfg_ce_en, cfg_ap_en;
  logic [1:0] cfg_pol_sel, cfg_ar_sel;
  logic sum_term, pt_pol, pt_data, k_term, gclk, pt_clk, pt_ce, gclr_n, pt_ar, pt_ap;
  logic q;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcell_reg i_mcell_reg (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_din_sel(cfg_din_sel),
    .cfg_pol_sel(cfg_pol_sel), .cfg_clk_sel(cfg_clk_sel), .cfg_ce_en(cfg_ce_en),
    .cfg_ar_sel(cfg_ar_sel), .cfg_ap_en(cfg_ap_en), .sum_term(sum_term),
    .pt_pol(pt_pol), .pt_data(pt_data), .k_term(k_term), .gclk(gclk),
    .pt_clk(pt_clk), .pt_ce(pt_ce), .gclr_n(gclr_n), .pt_ar(pt_ar),
    .pt_ap(pt_ap), .q(q)
  );

  // {mode[2:0], data, k, expected q}
  localparam logic [5:0] VEC [17] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b0, 1'b0}, {3'd0, 1'b1, 1'b0, 1'b1},
    {3'd1, 1'b1, 1'b0, 1'b0}, {3'd1, 1'b0, 1'b0, 1'b0}, {3'd1, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b1}, {3'd2, 1'b0, 1'b1, 1'b0}, {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b0}, {3'd2, 1'b1, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b1, 1'b0},
    {3'd3, 1'b1, 1'b0, 1'b1}, {3'd3, 1'b1, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b0, 1'b1, 1'b0}, {3'd0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
    end
  endtask

  task automatic pulse_g();
    @(negedge clk) gclk = 1'b1;
    @(negedge clk) gclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_p();
    @(negedge clk) pt_clk = 1'b1;
    @(negedge clk) pt_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_mode = 3'd0; cfg_din_sel = 1; cfg_pol_sel = 2'd0; cfg_clk_sel = 0;
    cfg_ce_en = 0; cfg_ar_sel = 2'd0; cfg_ap_en = 0; sum_term = 0; pt_pol = 0;
    pt_data = 0; k_term = 0; gclk = 0; pt_clk = 0; pt_ce = 1; gclr_n = 1;
    pt_ar = 0; pt_ap = 0;
    idle(3);
    chk("R1 during reset", 1'b0);
    rst_n = 1;
    idle(4);
    chk("R1 after reset", 1'b0);

    // R3 R4 R5 R6 mode table
    for (int v = 0; v < 17; v++) begin
      @(negedge clk);
      cfg_mode = VEC[v][5:3]; pt_data = VEC[v][2]; k_term = VEC[v][1];
      if (VEC[v][5:3] == 3'd3 && VEC[v][2] && VEC[v][1])
        $display("NOTE vector %0d: set and clear both high in SR mode, hold", v);
      pulse_g();
      case (VEC[v][5:3])
        3'd0: chk("R3 D mode", VEC[v][0]);
        3'd1: chk("R4 T mode", VEC[v][0]);
        3'd2: chk("R5 JK mode", VEC[v][0]);
        default: chk("R6 SR mode", VEC[v][0]);
      endcase
    end

    // R13 no edge, data changes
    @(negedge clk) cfg_mode = 3'd0; pt_data = 0;
    idle(3);
    chk("R13 no edge", 1'b1);

    // R2 data select
    @(negedge clk) cfg_din_sel = 0; sum_term = 1; cfg_pol_sel = 2'd1;
    pulse_g(); chk("R2 fixed high", 1'b0);
    @(negedge clk) cfg_pol_sel = 2'd0;
    pulse_g(); chk("R2 fixed low", 1'b1);
    @(negedge clk) cfg_pol_sel = 2'd2; pt_pol = 1;
    pulse_g(); chk("R2 term polarity", 1'b0);
    @(negedge clk) cfg_din_sel = 1; pt_data = 1;
    pulse_g(); chk("R2 dedicated term", 1'b1);
    @(negedge clk) pt_data = 0;
    pulse_g(); chk("R3 D clear", 1'b0);

    // R8 clock select
    @(negedge clk) cfg_clk_sel = 1; pt_data = 1;
    pulse_g(); chk("R8 global ignored", 1'b0);
    pulse_p(); chk("R8 term clock", 1'b1);

    // R9 clock enable
    @(negedge clk) cfg_ce_en = 1; pt_ce = 0; pt_data = 0;
    pulse_p(); chk("R9 enable unused on term clock", 1'b0);
    @(negedge clk) cfg_clk_sel = 0; pt_data = 1;
    pulse_g(); chk("R9 gated edge", 1'b0);
    @(negedge clk) pt_ce = 1;
    pulse_g(); chk("R9 enabled edge", 1'b1);
    @(negedge clk) cfg_ce_en = 0;

    // R7 latch
    @(negedge clk) cfg_mode = 3'd4; gclk = 1; pt_data = 0;
    @(negedge clk) chk("R7 transparent low", 1'b0);
    pt_data = 1;
    @(negedge clk) chk("R7 transparent high", 1'b1);
    gclk = 0; pt_data = 0;
    idle(2); chk("R7 hold", 1'b1);
    @(negedge clk) cfg_mode = 3'd0;

    // R10 clear sources
    @(negedge clk) gclr_n = 0; #1 chk("R10 off source", 1'b1);
    idle(2); chk("R10 off source later", 1'b1);
    gclr_n = 1;
    @(negedge clk) cfg_ar_sel = 2'd1; gclr_n = 0; #1 chk("R10 pin clear", 1'b0);
    @(negedge clk) gclr_n = 1;
    @(negedge clk) chk("R10 state cleared", 1'b0);
    pt_data = 1; pulse_g();
    @(negedge clk) cfg_ar_sel = 2'd2; pt_ar = 1; #1 chk("R10 term clear", 1'b0);
    @(negedge clk) pt_ar = 0;
    pulse_g();
    @(negedge clk) cfg_ar_sel = 2'd3; gclr_n = 0; #1 chk("R10 either clear", 1'b0);
    @(negedge clk) gclr_n = 1; cfg_ar_sel = 2'd0;

    // R11 set
    @(negedge clk) pt_ap = 1; #1 chk("R11 set disabled", 1'b0);
    idle(2); chk("R11 set disabled later", 1'b0);
    cfg_ap_en = 1; #1 chk("R11 set", 1'b1);
    @(negedge clk) pt_ap = 0;
    @(negedge clk) chk("R11 state set", 1'b1);

    // R12 priority
    cfg_ar_sel = 2'd2; pt_ar = 1; pt_ap = 1; #1 chk("R12 clear wins", 1'b0);
    @(negedge clk) pt_ar = 0; pt_ap = 0; cfg_ar_sel = 2'd0; cfg_ap_en = 0;

    // R1 reset mid-run
    pt_data = 1; pulse_g();
    rst_n = 0; #1 chk("R1 reset mid-run", 1'b0);
    @(negedge clk) rst_n = 1;
    idle(4); chk("R1 after second reset", 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule